// File: doc/BRIEF.md
# Spike-Timing Plasticity Learning Engine

This block adjusts a small array of synaptic weights from the relative timing of input (axon) spikes and output (neuron) spikes. Each axon and each neuron has an 8-bit activity trace. A spike loads the trace to full scale, and a decay tick lets it fall back geometrically. The engine never stores spike times. When a neuron fires, every weight feeding that neuron grows in proportion to the trace of its axon. When an axon fires, every weight it drives shrinks in proportion to the trace of the neuron it reaches. A recent opposite-side spike therefore causes a large change, and an old one causes a small change.

A signed reward value can be switched in as a third factor. It multiplies each change and can cancel or invert it. The weights live inside the block as a register array. A single-word port loads and reads them, so a host can preload the weights and later inspect them. The neuron dynamics and the spike routing belong to neighbouring blocks.

Top module: `stdp_engine`

## Requirements
- R1: A spike loads its own trace with 255. A post event loads the post trace at the clock edge where the event is sampled. A pre event loads the pre trace at the edge where the event is applied to the weights.
- R2: At an edge with `decay_tick` high, every trace that is not loaded at that edge becomes t − (t >> `decay_shift`). With `decay_tick` low, a trace keeps its value.
- R3: A post event on neuron i adds +((`a_plus` × pre trace j) >> 8) to every synapse (j, i) at the same edge. The pre traces used are the values held before that edge.
- R4: An applied pre event on axon j adds −((`a_minus` × post trace i) >> 8) to every synapse (j, i). The post traces used are the values held before that edge.
- R5: Synapses outside the addressed row or column keep their weights. A touched synapse whose final delta is zero also keeps its weight, even when that weight lies outside [`w_min`, `w_max`].
- R6: After a non-zero delta is added, the weight is clamped into [`w_min`, `w_max`].
- R7: With `reward_en` high, the delta becomes (delta × `reward`) >>> 4, an arithmetic shift that rounds toward minus infinity. A reward of zero therefore leaves the weights untouched, and a negative reward reverses the direction of the change.
- R8: A post event is always applied in its own cycle. A pre event sampled together with a post event is parked and applied at the first later edge that has no post event. `pre_busy` is high while an event is parked. A pre event presented while `pre_busy` is high is dropped.
- R9: Synapse (j, i) sits at address j×N_POST + i. A write through `mem_we` takes effect at the edge and overrides any learning update to the same word at that edge. `mem_rdata` returns the word at `mem_addr` as it stood before the edge, one cycle after the address is presented. Addresses beyond the array read as 0.
- R10: Reset clears all weights, all traces, `pre_busy` and `mem_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_valid | input | 1 | Axon spike event |
| pre_idx | input | clog2(N_PRE) | Axon number of the spike |
| post_valid | input | 1 | Neuron spike event |
| post_idx | input | clog2(N_POST) | Neuron number of the spike |
| decay_tick | input | 1 | Apply one decay step to all traces |
| decay_shift | input | 3 | Decay shift k |
| a_plus | input | 8 | Potentiation gain |
| a_minus | input | 8 | Depression gain |
| reward_en | input | 1 | Enable third-factor scaling |
| reward | input | 8 | Signed third-factor value |
| w_min | input | WW | Lower weight bound |
| w_max | input | WW | Upper weight bound |
| mem_we | input | 1 | Weight word write strobe |
| mem_addr | input | clog2(N_PRE×N_POST) | Weight word address |
| mem_wdata | input | WW | Weight word write data |
| mem_rdata | output | WW | Weight word read data, one cycle latency |
| pre_busy | output | 1 | A pre event is parked |

## Verification
The bench builds the engine with 4 axons, 3 neurons and 8-bit weights. Because the array is not square, a swapped row and column index or a wrong address stride leads straight to a mismatch. The 12 synapses leave address codes 12 to 15 and neuron code 3 unused, so reads and events outside the array can be exercised. With 8-bit weights, the bounds and a full-gain delta can reach the clamp from either side within a few spikes.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  localparam int TR_W    = 8;
  localparam int DELTA_W = 20;
  localparam logic [TR_W-1:0] TR_FULL = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_POT  = 2'd1,
    OP_DEP  = 2'd2
  } upd_op_e;

  // one geometric decay step: t - (t >> k)
  function automatic logic [TR_W-1:0] trace_decay(input logic [TR_W-1:0] t,
                                                  input logic [2:0] k);
    return t - (t >> k);
  endfunction

  // (gain * trace) >> 8, negated for depression
  function automatic logic signed [DELTA_W-1:0] base_delta(input logic [7:0] gain,
                                                           input logic [TR_W-1:0] t,
                                                           input logic depress);
    logic [15:0] prod;
    logic signed [DELTA_W-1:0] mag;
    prod = 16'(gain) * 16'(t);
    mag  = $signed({{(DELTA_W-8){1'b0}}, prod[15:8]});
    return depress ? -mag : mag;
  endfunction

  // third factor: (d * r) >>> 4 when enabled
  function automatic logic signed [DELTA_W-1:0] modulate(input logic signed [DELTA_W-1:0] d,
                                                         input logic en,
                                                         input logic signed [7:0] r);
    logic signed [DELTA_W+7:0] p;
    logic signed [DELTA_W+7:0] s;
    if (!en) return d;
    p = d * r;
    s = p >>> 4;
    return s[DELTA_W-1:0];
  endfunction

endpackage

// File: rtl/stdp_trace_bank.sv
module stdp_trace_bank #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [2:0]                    shift,
  input  logic                          set_en,
  input  logic [IW-1:0]                 set_idx,
  output logic [N*stdp_pkg::TR_W-1:0]   tr_flat
);
  localparam int TW = stdp_pkg::TR_W;

  for (genvar g = 0; g < N; g++) begin : g_tr
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    logic [TW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (set_en && set_idx == MY_IDX) q <= stdp_pkg::TR_FULL;
      else if (tick)                        q <= stdp_pkg::trace_decay(q, shift);
    end
    assign tr_flat[g*TW +: TW] = q;
  end

endmodule

// File: rtl/stdp_event_arb.sv
module stdp_event_arb #(
  parameter int PIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_valid,
  input  logic [PIW-1:0] pre_idx,
  input  logic           post_valid,
  output logic           do_pre,
  output logic [PIW-1:0] pre_sel_idx,
  output logic           pend_valid
);
  logic           pend_q;
  logic [PIW-1:0] pend_idx_q;
  logic           take_new;

  assign take_new    = pre_valid && !pend_q;
  assign do_pre      = !post_valid && (pend_q || take_new);
  assign pre_sel_idx = pend_q ? pend_idx_q : pre_idx;
  assign pend_valid  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else if (pend_q) begin
      if (do_pre) pend_q <= 1'b0;
    end else if (take_new && post_valid) begin
      pend_q     <= 1'b1;
      pend_idx_q <= pre_idx;
    end
  end

endmodule

// File: rtl/stdp_weight_array.sv
module stdp_weight_array #(
  parameter int NPRE  = 8,
  parameter int NPOST = 8,
  parameter int WW    = 8,
  parameter int PIW   = 3,
  parameter int QW    = 3,
  parameter int AW    = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  stdp_pkg::upd_op_e              op,
  input  logic [PIW-1:0]                 row_idx,
  input  logic [QW-1:0]                  col_idx,
  input  logic [NPRE*stdp_pkg::TR_W-1:0] pre_tr,
  input  logic [NPOST*stdp_pkg::TR_W-1:0] post_tr,
  input  logic [7:0]                     a_plus,
  input  logic [7:0]                     a_minus,
  input  logic                           reward_en,
  input  logic signed [7:0]              reward,
  input  logic [WW-1:0]                  w_min,
  input  logic [WW-1:0]                  w_max,
  input  logic                           mem_we,
  input  logic [AW-1:0]                  mem_addr,
  input  logic [WW-1:0]                  mem_wdata,
  output logic [WW-1:0]                  mem_rdata,
  output logic [NPRE*NPOST*WW-1:0]       w_flat,
  output logic [NPRE*NPOST-1:0]          upd_hit
);
  import stdp_pkg::*;

  localparam int NSYN = NPRE * NPOST;
  localparam int SW   = WW + DELTA_W + 1;

  function automatic logic [WW-1:0] apply_delta(input logic [WW-1:0] w,
                                                input logic signed [DELTA_W-1:0] d,
                                                input logic [WW-1:0] lo,
                                                input logic [WW-1:0] hi);
    logic signed [SW-1:0] s;
    s = $signed({{(DELTA_W+1){1'b0}}, w}) + $signed({{(WW+1){d[DELTA_W-1]}}, d});
    if (s < $signed({{(DELTA_W+1){1'b0}}, lo})) return lo;
    if (s > $signed({{(DELTA_W+1){1'b0}}, hi})) return hi;
    return s[WW-1:0];
  endfunction

  for (genvar j = 0; j < NPRE; j++) begin : g_row
    for (genvar i = 0; i < NPOST; i++) begin : g_col
      localparam int            K       = j * NPOST + i;
      localparam logic [PIW-1:0] ROW    = PIW'(j);
      localparam logic [QW-1:0]  COL    = QW'(i);
      localparam logic [AW-1:0]  MYADDR = AW'(K);
      logic                         touched;
      logic                         is_pot;
      logic [TR_W-1:0]              tr_use;
      logic signed [DELTA_W-1:0]    d_raw;
      logic signed [DELTA_W-1:0]    d_mod;
      logic [WW-1:0]                q;

      assign is_pot  = (op == OP_POT);
      assign touched = (is_pot && col_idx == COL) || (op == OP_DEP && row_idx == ROW);
      assign tr_use  = is_pot ? pre_tr[j*TR_W +: TR_W] : post_tr[i*TR_W +: TR_W];
      assign d_raw   = base_delta(is_pot ? a_plus : a_minus, tr_use, !is_pot);
      assign d_mod   = modulate(d_raw, reward_en, reward);
      assign upd_hit[K] = touched && (d_mod != '0);

      always_ff @(posedge clk) begin
        if (!rst_n)                          q <= '0;
        else if (mem_we && mem_addr == MYADDR) q <= mem_wdata;
        else if (upd_hit[K])                  q <= apply_delta(q, d_mod, w_min, w_max);
      end
      assign w_flat[K*WW +: WW] = q;
    end
  end

  logic [WW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NSYN; k++) begin
      if (mem_addr == AW'(k)) rd_mux = w_flat[k*WW +: WW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mem_rdata <= '0;
    else        mem_rdata <= rd_mux;
  end

endmodule

// File: rtl/stdp_engine.sv
module stdp_engine #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 8,
  parameter int WW     = 8,
  localparam int PIW   = (N_PRE  > 1) ? $clog2(N_PRE)  : 1,
  localparam int QW    = (N_POST > 1) ? $clog2(N_POST) : 1,
  localparam int AW    = (N_PRE * N_POST > 1) ? $clog2(N_PRE * N_POST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_valid,
  input  logic [PIW-1:0]    pre_idx,
  input  logic              post_valid,
  input  logic [QW-1:0]     post_idx,
  input  logic              decay_tick,
  input  logic [2:0]        decay_shift,
  input  logic [7:0]        a_plus,
  input  logic [7:0]        a_minus,
  input  logic              reward_en,
  input  logic signed [7:0] reward,
  input  logic [WW-1:0]     w_min,
  input  logic [WW-1:0]     w_max,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_addr,
  input  logic [WW-1:0]     mem_wdata,
  output logic [WW-1:0]     mem_rdata,
  output logic              pre_busy
);
  import stdp_pkg::*;

  // named internal events, observed by the bound checker
  logic                       do_pre;
  logic [PIW-1:0]             pre_sel_idx;
  logic                       pend_valid;
  upd_op_e                    op;
  logic [N_PRE*TR_W-1:0]      pre_tr;
  logic [N_POST*TR_W-1:0]     post_tr;
  logic [N_PRE*N_POST*WW-1:0] w_flat;
  logic [N_PRE*N_POST-1:0]    upd_hit;

  stdp_event_arb #(.PIW(PIW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pre_valid(pre_valid), .pre_idx(pre_idx), .post_valid(post_valid),
    .do_pre(do_pre), .pre_sel_idx(pre_sel_idx), .pend_valid(pend_valid)
  );

  assign op       = post_valid ? OP_POT : (do_pre ? OP_DEP : OP_NONE);
  assign pre_busy = pend_valid;

  stdp_trace_bank #(.N(N_PRE), .IW(PIW)) u_pre_tr (
    .clk(clk), .rst_n(rst_n), .tick(decay_tick), .shift(decay_shift),
    .set_en(do_pre), .set_idx(pre_sel_idx), .tr_flat(pre_tr)
  );

  stdp_trace_bank #(.N(N_POST), .IW(QW)) u_post_tr (
    .clk(clk), .rst_n(rst_n), .tick(decay_tick), .shift(decay_shift),
    .set_en(post_valid), .set_idx(post_idx), .tr_flat(post_tr)
  );

  stdp_weight_array #(
    .NPRE(N_PRE), .NPOST(N_POST), .WW(WW), .PIW(PIW), .QW(QW), .AW(AW)
  ) u_wts (
    .clk(clk), .rst_n(rst_n), .op(op),
    .row_idx(pre_sel_idx), .col_idx(post_idx),
    .pre_tr(pre_tr), .post_tr(post_tr),
    .a_plus(a_plus), .a_minus(a_minus),
    .reward_en(reward_en), .reward(reward),
    .w_min(w_min), .w_max(w_max),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .w_flat(w_flat), .upd_hit(upd_hit)
  );

endmodule

// File: rtl/stdp_engine_chk.sv
module stdp_engine_chk #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 8,
  parameter int WW     = 8,
  parameter int PIW    = 3,
  parameter int QW     = 3,
  parameter int AW     = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       post_valid,
  input logic [QW-1:0]              post_idx,
  input logic                       do_pre,
  input logic [PIW-1:0]             pre_sel_idx,
  input logic                       pend_valid,
  input logic [N_PRE*8-1:0]         pre_tr,
  input logic [N_POST*8-1:0]        post_tr,
  input logic [N_PRE*N_POST*WW-1:0] w_flat,
  input logic [N_PRE*N_POST-1:0]    upd_hit,
  input logic                       mem_we,
  input logic [AW-1:0]              mem_addr,
  input logic [WW-1:0]              w_min,
  input logic [WW-1:0]              w_max
);

  // R8: never two updates in one cycle
  a_r8_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(post_valid && do_pre));

  // R8: a parked pre event survives a competing post event
  a_r8_park_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && post_valid |=> pend_valid);

  for (genvar j = 0; j < N_PRE; j++) begin : g_pre
    localparam logic [PIW-1:0] ME = PIW'(j);
    // R1
    a_r1_pre_load: assert property (@(posedge clk) disable iff (!rst_n)
      do_pre && pre_sel_idx == ME |=> pre_tr[j*8 +: 8] == 8'hFF);
    // R2
    a_r2_pre_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_pre && pre_sel_idx == ME) |=> pre_tr[j*8 +: 8] <= $past(pre_tr[j*8 +: 8]));
  end

  for (genvar i = 0; i < N_POST; i++) begin : g_post
    localparam logic [QW-1:0] ME = QW'(i);
    // R1
    a_r1_post_load: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid && post_idx == ME |=> post_tr[i*8 +: 8] == 8'hFF);
    // R2
    a_r2_post_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      !(post_valid && post_idx == ME) |=> post_tr[i*8 +: 8] <= $past(post_tr[i*8 +: 8]));
  end

  for (genvar k = 0; k < N_PRE*N_POST; k++) begin : g_syn
    localparam logic [AW-1:0] ME = AW'(k);
    // R5
    a_r5_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_hit[k] && !(mem_we && mem_addr == ME) |=> $stable(w_flat[k*WW +: WW]));
    // R6
    a_r6_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hit[k] && !(mem_we && mem_addr == ME) && w_min <= w_max |=>
        w_flat[k*WW +: WW] >= $past(w_min) && w_flat[k*WW +: WW] <= $past(w_max));
  end

endmodule

bind stdp_engine stdp_engine_chk #(
  .N_PRE(N_PRE), .N_POST(N_POST), .WW(WW), .PIW(PIW), .QW(QW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_idx(post_idx),
  .do_pre(do_pre), .pre_sel_idx(pre_sel_idx), .pend_valid(pend_valid),
  .pre_tr(pre_tr), .post_tr(post_tr), .w_flat(w_flat), .upd_hit(upd_hit),
  .mem_we(mem_we), .mem_addr(mem_addr), .w_min(w_min), .w_max(w_max)
);

// File: tb/tb_stdp_engine.sv
module tb_stdp_engine;
  localparam int NPRE  = 4;
  localparam int NPOST = 3;
  localparam int WW    = 8;
  localparam int NSYN  = NPRE * NPOST;
  localparam int PIW   = 2;
  localparam int QW    = 2;
  localparam int AW    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pre_valid = 1'b0;
  logic [PIW-1:0]    pre_idx = '0;
  logic              post_valid = 1'b0;
  logic [QW-1:0]     post_idx = '0;
  logic              decay_tick = 1'b0;
  logic [2:0]        decay_shift = 3'd2;
  logic [7:0]        a_plus = 8'd128;
  logic [7:0]        a_minus = 8'd64;
  logic              reward_en = 1'b0;
  logic signed [7:0] reward = '0;
  logic [WW-1:0]     w_min = '0;
  logic [WW-1:0]     w_max = 8'd255;
  logic              mem_we = 1'b0;
  logic [AW-1:0]     mem_addr = '0;
  logic [WW-1:0]     mem_wdata = '0;
  logic [WW-1:0]     mem_rdata;
  logic              pre_busy;

  always #2 clk = ~clk;

  stdp_engine #(.N_PRE(NPRE), .N_POST(NPOST), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .pre_valid(pre_valid), .pre_idx(pre_idx),
    .post_valid(post_valid), .post_idx(post_idx), .decay_tick(decay_tick),
    .decay_shift(decay_shift), .a_plus(a_plus), .a_minus(a_minus),
    .reward_en(reward_en), .reward(reward), .w_min(w_min), .w_max(w_max),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pre_busy(pre_busy)
  );

  int    total = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  // behavioural reference state
  int m_pre[NPRE];
  int m_post[NPOST];
  int m_w[NSYN];
  bit m_pend;
  int m_pend_idx;
  int m_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : ref_model
    int opre[NPRE];
    int opost[NPOST];
    bit pot, dep;
    int col, row, d, s, a;
    if (!rst_n) begin
      foreach (m_pre[j])  m_pre[j] = 0;
      foreach (m_post[i]) m_post[i] = 0;
      foreach (m_w[k])    m_w[k] = 0;
      m_pend = 0; m_pend_idx = 0; m_rd = 0;
    end else begin
      opre = m_pre;
      opost = m_post;
      m_rd = (int'(mem_addr) < NSYN) ? m_w[mem_addr] : 0;
      pot = post_valid; dep = 0; col = int'(post_idx); row = 0;
      if (!pot) begin
        if (m_pend) begin dep = 1; row = m_pend_idx; m_pend = 0; end
        else if (pre_valid) begin dep = 1; row = int'(pre_idx); end
      end else if (pre_valid && !m_pend) begin
        m_pend = 1; m_pend_idx = int'(pre_idx);
      end
      for (int j = 0; j < NPRE; j++) begin
        for (int i = 0; i < NPOST; i++) begin
          a = j * NPOST + i;
          if ((pot && i == col) || (dep && j == row)) begin
            if (pot) d = (int'(a_plus) * opre[j]) / 256;
            else     d = -((int'(a_minus) * opost[i]) / 256);
            if (reward_en) d = (d * int'(reward)) >>> 4;
            if (d != 0) begin
              s = m_w[a] + d;
              if (s < int'(w_min)) s = int'(w_min);
              if (s > int'(w_max)) s = int'(w_max);
              m_w[a] = s;
            end
          end
        end
      end
      if (mem_we && int'(mem_addr) < NSYN) m_w[mem_addr] = int'(mem_wdata);
      for (int j = 0; j < NPRE; j++) begin
        if (dep && j == row)  m_pre[j] = 255;
        else if (decay_tick)  m_pre[j] = opre[j] - (opre[j] >> decay_shift);
      end
      for (int i = 0; i < NPOST; i++) begin
        if (pot && i == col)  m_post[i] = 255;
        else if (decay_tick)  m_post[i] = opost[i] - (opost[i] >> decay_shift);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(pre_busy == m_pend, "R8", "pre_busy", int'(pre_busy), int'(m_pend));
      chk(int'(mem_rdata) == m_rd, cur_req, "mem_rdata", int'(mem_rdata), m_rd);
    end
  end

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic pre_ev(input int j);
    pre_valid = 1'b1; pre_idx = PIW'(j);
    @(negedge clk);
    pre_valid = 1'b0;
  endtask

  task automatic post_ev(input int i);
    post_valid = 1'b1; post_idx = QW'(i);
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    decay_tick = 1'b1;
    idle(n);
    decay_tick = 1'b0;
  endtask

  task automatic wr(input int a, input int v);
    mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = WW'(v);
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  // sweeps every address, including the unused codes past the array
  task automatic scan(input string req);
    cur_req = req;
    for (int a = 0; a < 16; a++) begin
      mem_addr = AW'(a);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R10: reset contents
    scan("R10");
    // R9: preload through the port
    cur_req = "R9";
    for (int a = 0; a < NSYN; a++) wr(a, 100 + 3 * a);
    scan("R9");
    // R1 R2 R3: pre first, decay, then post potentiates column 2
    cur_req = "R3";
    pre_ev(1);
    ticks(3);
    post_ev(2);
    scan("R3");
    // R4: post then pre depresses row 3
    cur_req = "R4";
    post_ev(0);
    ticks(1);
    pre_ev(3);
    scan("R4");
    // R2: decay shift extremes
    cur_req = "R2";
    decay_shift = 3'd0;
    pre_ev(0);
    ticks(5);
    post_ev(1);
    decay_shift = 3'd7;
    post_ev(2);
    ticks(4);
    pre_ev(2);
    decay_shift = 3'd1;
    ticks(2);
    post_ev(0);
    scan("R2");
    // R6: clamp at both bounds
    cur_req = "R6";
    w_min = 8'd90; w_max = 8'd130; a_plus = 8'd255; a_minus = 8'd255;
    for (int r = 0; r < 4; r++) begin pre_ev(r); post_ev(r % NPOST); end
    for (int r = 0; r < 4; r++) begin post_ev(r % NPOST); pre_ev(3 - r); end
    scan("R6");
    // R5: out-of-range weight untouched by a zero delta
    cur_req = "R5";
    wr(4, 200);
    ticks(40);
    pre_ev(1);
    post_ev(3);
    scan("R5");
    // R7: reward scaling, zero, negative, positive
    cur_req = "R7";
    w_min = 8'd0; w_max = 8'd255; a_plus = 8'd200; a_minus = 8'd150;
    reward_en = 1'b1;
    reward = -8'sd20;  pre_ev(2); post_ev(1);
    reward = 8'sd0;    pre_ev(0); post_ev(2); pre_ev(1);
    reward = 8'sd37;   post_ev(0); pre_ev(3);
    reward = -8'sd128; pre_ev(0); post_ev(0);
    reward_en = 1'b0;
    scan("R7");
    // R8: simultaneous events, drop while busy, park across posts
    cur_req = "R8";
    pre_valid = 1'b1; pre_idx = 2'd2; post_valid = 1'b1; post_idx = 2'd1;
    @(negedge clk);
    pre_idx = 2'd3; post_valid = 1'b0;
    @(negedge clk);
    pre_valid = 1'b0;
    idle(2);
    pre_valid = 1'b1; pre_idx = 2'd0; post_valid = 1'b1; post_idx = 2'd0;
    @(negedge clk);
    pre_valid = 1'b0; post_idx = 2'd2;
    @(negedge clk);
    post_valid = 1'b0;
    idle(2);
    scan("R8");
    // R9: port write wins over a learning update in the same cycle
    cur_req = "R9";
    post_valid = 1'b1; post_idx = 2'd1;
    mem_we = 1'b1; mem_addr = 4'd4; mem_wdata = 8'd7;
    @(negedge clk);
    post_valid = 1'b0; mem_we = 1'b0;
    scan("R9");
    // R5: mixed stimulus, every clock compared
    cur_req = "R5";
    for (int c = 0; c < 600; c++) begin
      int rv;
      rv = int'($urandom);
      pre_valid   = rv[0] & rv[1];
      pre_idx     = PIW'(rv[5:4]);
      post_valid  = rv[2] & rv[3];
      post_idx    = QW'(rv[7:6] % 3);
      decay_tick  = rv[8];
      decay_shift = 3'(rv[11:9]);
      reward_en   = rv[12] & rv[13];
      reward      = 8'(rv[21:14]);
      mem_we      = (rv[23:22] == 2'b11) && rv[24];
      mem_addr    = AW'(rv[27:25] + rv[29:28]);
      mem_wdata   = 8'(rv[31:24]);
      a_plus      = 8'(rv[19:12]);
      a_minus     = 8'(rv[27:20]);
      @(negedge clk);
    end
    pre_valid = 1'b0; post_valid = 1'b0; decay_tick = 1'b0;
    mem_we = 1'b0; reward_en = 1'b0;
    idle(2);
    scan("R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule